// File: doc/BRIEF.md
# Redirection-Table Interrupt Router

This block collects a set of interrupt input lines and sends each one on as a delivery request. It sends them through a per-line 64-bit redirection entry, to one downstream consumer. Each entry gives the line a vector, a destination, a delivery mode and a destination mode. It also sets the sense of the line (active high or active low, edge or level) and a mask. Software does not see the table as a flat address map. It first writes an index into a selector register. It then reads or writes the chosen internal register 32 bits at a time through a data window. A 64-bit entry is therefore always reached as a low (even) word and a high (odd) word, and each word can be updated on its own.

Inputs that go active set a bit in a pending mask. An entry that is masked still collects a pending bit. It is delivered as soon as the mask is cleared. The lowest-numbered eligible line is delivered first. Only one delivery is in flight at a time. It is presented on a valid/ready handshake, and its pending bit clears when the handshake completes. Level-triggered lines are held off by a remote-IRR flag after delivery until the line goes inactive.

Top module: `irq_router`

## Requirements
- R1: The window at selector index 0x01 reads 0x00170011 for 24 pins: bits 23:16 hold the highest pin number and bits 7:0 hold 0x11. Writes to it are ignored. Index 0x00 is an ID register in which only bits 27:24 are writable, and all other bits read zero.
- R2: A write to offset 0x00 sets an 8-bit selector that reads back in bits 7:0. Offset 0x10 is the data window onto the selected register: 0x00 is ID, 0x01 is version, 0x10+2n is the low word of entry n and 0x11+2n is its high word. Indices with no register read zero and ignore writes, and any other offset reads zero.
- R3: After reset the selector is 0, the ID is 0, and every entry reads low word 0x00010000 (masked) and high word 0. No delivery is offered.
- R4: Low word layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12 (read-only), polarity 13, remote IRR 14 (read-only), trigger mode 15, mask 16. Other bits read zero. High word layout: destination in bits 31:24, other bits zero. A low-word write leaves the destination unchanged, and a high-word write leaves every low-word field unchanged.
- R5: With trigger mode 0 (edge), each inactive-to-active transition of the line sets the pending bit, and a line held active gives exactly one delivery. The line is active when it is high with polarity 0, or low with polarity 1.
- R6: With trigger mode 1 (level), the pending bit is set while the line is active and remote IRR is clear. Delivering the line sets remote IRR. Remote IRR clears when the line goes inactive. A line that goes inactive before it is delivered loses its pending bit.
- R7: A masked line still sets its pending bit (delivery status reads 1) but is not delivered. Clearing the mask then delivers it.
- R8: Among eligible lines the lowest-numbered one is delivered first. While valid is high and ready is low, valid and all delivery fields hold steady. After a handshake, valid is low for at least one cycle.
- R9: Delivery status reads 1 exactly while the line's pending bit is set. The bit clears on the cycle in which valid and ready are both high.
- R10: A delivery carries the entry's vector, destination, delivery mode, destination mode and trigger mode, together with the line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset (0x00 selector, 0x10 data window) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | NUM_PINS | Interrupt input lines |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Consumer accepts the delivery |
| dlv_vector | output | 8 | Vector of the delivered line |
| dlv_dest | output | 8 | Destination field |
| dlv_mode | output | 3 | Delivery mode field |
| dlv_logical | output | 1 | Destination mode field |
| dlv_level | output | 1 | Trigger mode of the delivered line |
| dlv_pin | output | PIN_W | Number of the delivered line |

## Verification
The bench builds the router with its default of 24 lines. This makes the version word 0x00170011 and puts the last entry at selector index 0x3E, so the top of the table and the first index past it (0x40) can both be reached. With 24 lines, the priority scan can be tested with lines at both ends of the vector, and an earlier-numbered line can arrive while a later one waits. The polarity test uses a level-to-edge reprogramming sequence so that no spurious pending bit is left behind.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  // register offsets seen by software
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  // selector indices
  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_TBL = 8'h10;

  // low-word bit positions
  localparam int B_MODE    = 8;
  localparam int B_LOGICAL = 11;
  localparam int B_STATUS  = 12;
  localparam int B_POL     = 13;
  localparam int B_RIRR    = 14;
  localparam int B_LEVEL   = 15;
  localparam int B_MASK    = 16;
  // high-word position of the destination
  localparam int B_DEST    = 24;

  // only the writable fields are stored
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       pol;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vec;
  } rt_entry_t;

endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [7:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_PINS-1:0]        pend,
  input  logic [NUM_PINS-1:0]        rirr,
  output rt_entry_t [NUM_PINS-1:0]   tbl_o,
  output logic [7:0]                 sel_o
);

  localparam int TBL_SPAN = 2 * NUM_PINS;
  localparam logic [31:0] VERSION = {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'h11};

  logic [7:0] sel_q, sel_d;
  logic [3:0] id_q, id_d;
  logic       win_wr;
  logic [7:0] sel_off;
  logic       tbl_hit;
  logic       odd_half;
  logic [IDX_W-1:0] ent_idx;
  logic [31:0] win_data;
  logic       unused_wdata;

  assign unused_wdata = ^reg_wdata[23:17];

  assign win_wr   = reg_wr && (reg_addr == OFS_WIN);
  assign sel_off  = sel_q - IDX_TBL;
  assign tbl_hit  = (sel_q >= IDX_TBL) && ({1'b0, sel_off} < 9'(TBL_SPAN));
  assign odd_half = sel_off[0];
  assign ent_idx  = IDX_W'(sel_off >> 1);

  // selector and ID next state
  always_comb begin
    sel_d = sel_q;
    if (reg_wr && (reg_addr == OFS_SEL)) sel_d = reg_wdata[7:0];
  end

  always_comb begin
    id_d = id_q;
    if (win_wr && (sel_q == IDX_ID)) id_d = reg_wdata[27:24];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      sel_q <= sel_d;
      id_q  <= id_d;
    end
  end

  // one storage slice per table entry
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    rt_entry_t ent_q, ent_d;
    logic      lo_we, hi_we;

    assign lo_we = win_wr && tbl_hit && (ent_idx == IDX_W'(g)) && !odd_half;
    assign hi_we = win_wr && tbl_hit && (ent_idx == IDX_W'(g)) &&  odd_half;

    always_comb begin
      ent_d = ent_q;
      if (lo_we) begin
        ent_d.vec     = reg_wdata[7:0];
        ent_d.mode    = reg_wdata[B_MODE +: 3];
        ent_d.logical = reg_wdata[B_LOGICAL];
        ent_d.pol     = reg_wdata[B_POL];
        ent_d.level   = reg_wdata[B_LEVEL];
        ent_d.mask    = reg_wdata[B_MASK];
      end
      if (hi_we) begin
        ent_d.dest    = reg_wdata[B_DEST +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q      <= '0;
        ent_q.mask <= 1'b1;
      end else if (lo_we || hi_we) begin
        ent_q <= ent_d;
      end
    end

    assign tbl_o[g] = ent_q;
  end

  // data window read path
  always_comb begin
    win_data = '0;
    if (sel_q == IDX_ID) begin
      win_data[27:24] = id_q;
    end else if (sel_q == IDX_VER) begin
      win_data = VERSION;
    end else if (tbl_hit) begin
      if (odd_half) begin
        win_data[B_DEST +: 8] = tbl_o[ent_idx].dest;
      end else begin
        win_data[7:0]          = tbl_o[ent_idx].vec;
        win_data[B_MODE +: 3]  = tbl_o[ent_idx].mode;
        win_data[B_LOGICAL]    = tbl_o[ent_idx].logical;
        win_data[B_STATUS]     = pend[ent_idx];
        win_data[B_POL]        = tbl_o[ent_idx].pol;
        win_data[B_RIRR]       = rirr[ent_idx];
        win_data[B_LEVEL]      = tbl_o[ent_idx].level;
        win_data[B_MASK]       = tbl_o[ent_idx].mask;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_SEL: reg_rdata = {24'h0, sel_q};
      OFS_WIN: reg_rdata = win_data;
      default: reg_rdata = '0;
    endcase
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/irq_rt_pending.sv
module irq_rt_pending #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] pol_vec,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic                hs_fire,
  input  logic [PIN_W-1:0]    hs_pin,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] rirr_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic act, prev_q, prev_d;
    logic pend_q, pend_d;
    logic rirr_q, rirr_d;
    logic hs_this;

    // polarity first, then edge or level detection
    assign act     = irq_in[g] ^ pol_vec[g];
    assign hs_this = hs_fire && (hs_pin == PIN_W'(g));
    assign prev_d  = act;

    always_comb begin
      pend_d = pend_q;
      if (hs_this) pend_d = 1'b0;
      if (level_vec[g]) begin
        if (!act)                      pend_d = 1'b0;
        else if (!rirr_q && !hs_this)  pend_d = 1'b1;
      end else if (act && !prev_q) begin
        pend_d = 1'b1;
      end
    end

    always_comb begin
      rirr_d = rirr_q;
      if (!level_vec[g] || !act) rirr_d = 1'b0;
      else if (hs_this)          rirr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
        rirr_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
        pend_q <= pend_d;
        rirr_q <= rirr_d;
      end
    end

    assign pend_o[g] = pend_q;
    assign rirr_o[g] = rirr_q;
  end

endmodule

// File: rtl/irq_rt_deliver.sv
module irq_rt_deliver
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PINS-1:0]      elig,
  input  rt_entry_t [NUM_PINS-1:0] tbl,
  input  logic                     dlv_ready,
  output logic                     dlv_valid,
  output logic [7:0]               dlv_vector,
  output logic [7:0]               dlv_dest,
  output logic [2:0]               dlv_mode,
  output logic                     dlv_logical,
  output logic                     dlv_level,
  output logic [PIN_W-1:0]         dlv_pin,
  output logic                     hs_fire
);

  logic             found;
  logic [PIN_W-1:0] pick;
  logic             valid_q, valid_d;
  logic             load;
  rt_entry_t        pick_ent;
  rt_entry_t        ent_q;
  logic [PIN_W-1:0] pin_q;
  logic             unused_tbl;

  assign unused_tbl = ^{tbl[0].mask, tbl[0].pol};

  // lowest-numbered eligible line wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  assign pick_ent = tbl[pick];
  assign load     = !valid_q && found;
  assign hs_fire  = valid_q && dlv_ready;

  always_comb begin
    valid_d = valid_q;
    if (!valid_q)      valid_d = found;
    else if (dlv_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      pin_q <= '0;
    end else if (load) begin
      ent_q <= pick_ent;
      pin_q <= pick;
    end
  end

  assign dlv_valid   = valid_q;
  assign dlv_vector  = ent_q.vec;
  assign dlv_dest    = ent_q.dest;
  assign dlv_mode    = ent_q.mode;
  assign dlv_logical = ent_q.logical;
  assign dlv_level   = ent_q.level;
  assign dlv_pin     = pin_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [7:0]          dlv_vector,
  output logic [7:0]          dlv_dest,
  output logic [2:0]          dlv_mode,
  output logic                dlv_logical,
  output logic                dlv_level,
  output logic [PIN_W-1:0]    dlv_pin
);

  logic rst_m_q, rst_sync_n;
  rt_entry_t [NUM_PINS-1:0] tbl;
  logic [NUM_PINS-1:0] pend_vec, rirr_vec, mask_vec, pol_vec, level_vec, elig_vec;
  logic [7:0]          sel_idx;
  logic                hs_fire;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fld
    assign mask_vec[g]  = tbl[g].mask;
    assign pol_vec[g]   = tbl[g].pol;
    assign level_vec[g] = tbl[g].level;
  end

  assign elig_vec = pend_vec & ~mask_vec;

  irq_rt_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend      (pend_vec),
    .rirr      (rirr_vec),
    .tbl_o     (tbl),
    .sel_o     (sel_idx)
  );

  irq_rt_pending #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_in    (irq_in),
    .pol_vec   (pol_vec),
    .level_vec (level_vec),
    .hs_fire   (hs_fire),
    .hs_pin    (dlv_pin),
    .pend_o    (pend_vec),
    .rirr_o    (rirr_vec)
  );

  irq_rt_deliver #(.NUM_PINS(NUM_PINS)) u_dlv (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .elig        (elig_vec),
    .tbl         (tbl),
    .dlv_ready   (dlv_ready),
    .dlv_valid   (dlv_valid),
    .dlv_vector  (dlv_vector),
    .dlv_dest    (dlv_dest),
    .dlv_mode    (dlv_mode),
    .dlv_logical (dlv_logical),
    .dlv_level   (dlv_level),
    .dlv_pin     (dlv_pin),
    .hs_fire     (hs_fire)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          reg_addr,
  input logic [31:0]         reg_rdata,
  input logic [7:0]          sel_idx,
  input logic [NUM_PINS-1:0] elig,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [7:0]          dlv_vector,
  input logic [7:0]          dlv_dest,
  input logic [2:0]          dlv_mode,
  input logic                dlv_logical,
  input logic                dlv_level,
  input logic [PIN_W-1:0]    dlv_pin
);

  logic [NUM_PINS-1:0] elig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= elig;
  end

  AST_ID_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h10 && sel_idx == 8'h00) |-> (reg_rdata[31:28] == 4'h0 && reg_rdata[23:0] == 24'h0)); // R1

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector) && $stable(dlv_dest) &&
                                   $stable(dlv_mode) && $stable(dlv_logical) &&
                                   $stable(dlv_level) && $stable(dlv_pin))); // R8

  AST_GAP_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready) |=> !dlv_valid); // R8

  AST_LAUNCH_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> elig_q[dlv_pin]); // R7

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> ((elig_q & ~({NUM_PINS{1'b1}} << dlv_pin)) == '0)); // R8

  AST_PIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (int'(dlv_pin) < NUM_PINS)); // R10

endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .sel_idx     (sel_idx),
  .elig        (elig_vec),
  .dlv_valid   (dlv_valid),
  .dlv_ready   (dlv_ready),
  .dlv_vector  (dlv_vector),
  .dlv_dest    (dlv_dest),
  .dlv_mode    (dlv_mode),
  .dlv_logical (dlv_logical),
  .dlv_level   (dlv_level),
  .dlv_pin     (dlv_pin)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

  localparam int N  = 24;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  irq_in;
  logic          dlv_valid, dlv_ready;
  logic [7:0]    dlv_vector, dlv_dest;
  logic [2:0]    dlv_mode;
  logic          dlv_logical, dlv_level;
  logic [PW-1:0] dlv_pin;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_router #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_mode(dlv_mode), .dlv_logical(dlv_logical),
    .dlv_level(dlv_level), .dlv_pin(dlv_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] mode,
                                          input bit logical, input bit pol, input bit level,
                                          input bit mask);
    return {15'h0, mask, level, 1'b0, pol, 1'b0, logical, mode, vec};
  endfunction

  function automatic logic [7:0] lo_idx(input int pin);
    return 8'(16 + 2 * pin);
  endfunction

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dlv_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic handshake;
    @(negedge clk); dlv_ready = 1'b1;
    @(negedge clk); dlv_ready = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dlv_valid) seen = 1'b1;
    end
    chk(req, {31'h0, seen}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d);               chk("R3 selector after reset", d, 32'h0);
    chk("R3 no delivery after reset", {31'h0, dlv_valid}, 32'h0);
    win_rd(8'h00, d);           chk("R3 ID after reset", d, 32'h0);
    win_rd(lo_idx(0), d);       chk("R3 entry0 low masked", d, 32'h0001_0000);
    win_rd(lo_idx(23), d);      chk("R3 entry23 low masked", d, 32'h0001_0000);
    win_rd(lo_idx(23) + 8'h1, d); chk("R3 entry23 high", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    win_rd(8'h01, d);           chk("R1 version", d, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);               chk("R1 version write ignored", d, 32'h0017_0011);
    win_wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, d);               chk("R1 ID writable bits only", d, 32'h0F00_0000);
    wr(8'h00, 32'h0000_0140);
    rd(8'h00, d);               chk("R2 selector readback low byte", d, 32'h40);
    rd(8'h10, d);               chk("R2 index past table reads zero", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    win_rd(lo_idx(23), d);      chk("R2 write past table ignored", d, 32'h0001_0000);
    win_rd(8'h05, d);           chk("R2 unused index reads zero", d, 32'h0);
    rd(8'h08, d);               chk("R2 other offset reads zero", d, 32'h0);
    win_wr(8'h00, 32'h0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    win_wr(lo_idx(3) + 8'h1, 32'hABFF_FFFF);
    rd(8'h10, d);               chk("R4 high word keeps only destination", d, 32'hAB00_0000);
    win_wr(lo_idx(3), 32'hFFFF_4FAB);
    rd(8'h10, d);               chk("R4 low word fields, read-only bits clear", d, 32'h0001_0FAB);
    win_rd(lo_idx(3) + 8'h1, d); chk("R4 low write keeps destination", d, 32'hAB00_0000);
    win_wr(lo_idx(3) + 8'h1, 32'h1234_5678);
    win_rd(lo_idx(3), d);       chk("R4 high write keeps low fields", d, 32'h0001_0FAB);
    win_rd(lo_idx(3) + 8'h1, d); chk("R4 new destination", d, 32'h1200_0000);
  endtask

  task automatic t_edge;
    logic [31:0] d; bit got;
    win_wr(lo_idx(5) + 8'h1, 32'h2200_0000);
    win_wr(lo_idx(5), lo_word(8'h35, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    wr(8'h00, {24'h0, lo_idx(5)});
    @(negedge clk); irq_in[5] = 1'b1;
    wait_valid(got);            chk("R5 edge delivery", {31'h0, got}, 32'h1);
    chk("R10 vector", {24'h0, dlv_vector}, 32'h35);
    chk("R10 destination", {24'h0, dlv_dest}, 32'h22);
    chk("R10 mode/logical/level", {28'h0, dlv_mode, dlv_logical}, {28'h0, 3'd1, 1'b1});
    chk("R10 trigger mode edge", {31'h0, dlv_level}, 32'h0);
    chk("R10 pin number", {27'h0, dlv_pin}, 32'd5);
    rd(8'h10, d);               chk("R9 status while pending", {31'h0, d[12]}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 valid held without ready", {26'h0, dlv_valid, dlv_pin}, {26'h0, 1'b1, 5'd5});
    handshake;
    chk("R8 valid drops after handshake", {31'h0, dlv_valid}, 32'h0);
    rd(8'h10, d);               chk("R9 status clears on handshake", {31'h0, d[12]}, 32'h0);
    quiet(6, "R5 held line gives one delivery");
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk); irq_in[5] = 1'b1;
    wait_valid(got);            chk("R5 second edge delivers again", {31'h0, got}, 32'h1);
    handshake;
    @(negedge clk); irq_in[5] = 1'b0;
  endtask

  task automatic t_polarity;
    bit got;
    // level + active-low, masked: pending clears when the line is raised
    win_wr(lo_idx(7), lo_word(8'h47, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1));
    @(negedge clk); irq_in[7] = 1'b1;
    win_wr(lo_idx(7), lo_word(8'h47, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    quiet(4, "R5 inactive-low line no delivery");
    @(negedge clk); irq_in[7] = 1'b0;
    wait_valid(got);
    chk("R5 active-low falling edge delivers", {26'h0, got, dlv_pin}, {26'h0, 1'b1, 5'd7});
    handshake;
  endtask

  task automatic t_level;
    logic [31:0] d; bit got;
    win_wr(lo_idx(9), lo_word(8'h59, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    @(negedge clk); irq_in[9] = 1'b1;
    wait_valid(got);
    chk("R6 level delivery", {26'h0, got, dlv_pin}, {26'h0, 1'b1, 5'd9});
    chk("R10 trigger mode level", {31'h0, dlv_level}, 32'h1);
    handshake;
    wr(8'h00, {24'h0, lo_idx(9)});
    rd(8'h10, d);               chk("R6 remote IRR set", {31'h0, d[14]}, 32'h1);
    quiet(6, "R6 no repeat while remote IRR set");
    @(negedge clk); irq_in[9] = 1'b0;
    rd(8'h10, d);               chk("R6 remote IRR clears when inactive", {30'h0, d[14], d[12]}, 32'h0);
    win_wr(lo_idx(9), lo_word(8'h59, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    @(negedge clk); irq_in[9] = 1'b1;
    rd(8'h10, d);               chk("R7 masked level pending", {31'h0, d[12]}, 32'h1);
    @(negedge clk); irq_in[9] = 1'b0;
    rd(8'h10, d);               chk("R6 deassert clears pending", {31'h0, d[12]}, 32'h0);
    wr(8'h10, lo_word(8'h59, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    quiet(6, "R6 withdrawn level not delivered");
  endtask

  task automatic t_mask;
    logic [31:0] d; bit got;
    win_wr(lo_idx(11), lo_word(8'h6B, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1));
    @(negedge clk); irq_in[11] = 1'b1;
    @(negedge clk); irq_in[11] = 1'b0;
    rd(8'h10, d);               chk("R7 masked edge still pending", {31'h0, d[12]}, 32'h1);
    quiet(5, "R7 masked line not delivered");
    wr(8'h10, lo_word(8'h6B, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    wait_valid(got);
    chk("R7 unmask delivers held line", {26'h0, got, dlv_pin}, {26'h0, 1'b1, 5'd11});
    chk("R10 held vector and mode", {21'h0, dlv_mode, dlv_vector}, {21'h0, 3'd2, 8'h6B});
    handshake;
  endtask

  task automatic t_priority;
    bit got;
    win_wr(lo_idx(1),  lo_word(8'h81, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    win_wr(lo_idx(2),  lo_word(8'h82, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    win_wr(lo_idx(20), lo_word(8'h94, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); irq_in[2] = 1'b1; irq_in[20] = 1'b1;
    wait_valid(got);
    chk("R8 lowest pin first", {26'h0, got, dlv_pin}, {26'h0, 1'b1, 5'd2});
    @(negedge clk); irq_in[1] = 1'b1;
    handshake;
    wait_valid(got);
    chk("R8 newer lower pin beats waiting higher pin", {26'h0, got, dlv_pin}, {26'h0, 1'b1, 5'd1});
    handshake;
    wait_valid(got);
    chk("R8 remaining pin last", {24'h0, dlv_vector}, 32'h94);
    handshake;
    quiet(5, "R9 all pending cleared");
    @(negedge clk); irq_in = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_in = '0; dlv_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_halves;
    t_edge;
    t_polarity;
    t_level;
    t_mask;
    t_priority;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule